// File: doc/BRIEF.md
# PWM Audio DAC Core

This core turns 16-bit PCM samples into one pulse-width-modulated output per channel, for mono or stereo playback. A free-running period counter runs for 256 or 1024 clocks. On each channel a comparator sets the output high for a number of clocks equal to that channel's duty value. The duty value comes from the incoming sample after optional sign conversion and a left shift. It is then cut to the top 8 or 10 bits.

A small register port is used for configuration and data. The control word is at byte offset 0x04 and the sample word is at byte offset 0x00. A write to the sample word fills a one-entry holding register. The core raises `sampleReq` while it is enabled and that register is empty, so a DMA engine can refill it. The held sample moves into the active duty registers only on a period boundary, and only after the programmed repeat count has run out. The fast-change option lets it move at the next boundary instead. If no new sample has arrived, the previous duty values stay in use.

Top module: `pwm_audio_dac`

## Requirements
- R1: After reset, and whenever control bit 0 (enable) is 0, `pwmLeft`, `pwmRight` and `sampleReq` are all low.
- R2: A write to byte offset 0x00 loads the holding register. A write to offset 0x04 loads control bits 17:0. Writes to any other offset have no effect; in particular they do not fill an empty holding register.
- R3: Control bit 1 sets the period: 0 gives 256 clocks with an 8-bit duty, 1 gives 1024 clocks with a 10-bit duty.
- R4: Control bits 3:2 set the alignment. With period P, duty d and period position c (0 to P-1): value 0 is high for c < d; value 1 is high for c >= P-d; value 2 is high for lo <= c < lo+d, where lo = (P-d)/2 rounded down. Value 3 behaves as value 0.
- R5: Control bits 12:4 hold the repeat count minus one. A sample stays active for that many plus one whole periods, and only then is the next held sample taken.
- R6: Control bit 14 set inverts bit 15 of each sample before further processing, which turns two's-complement data into offset binary. When the bit is clear, samples are treated as unsigned.
- R7: Control bits 17:15 give a left shift of 0 to 7. It is applied to the 16-bit sample, and bits shifted past bit 15 are dropped. The duty is then bits 15:8 (8-bit period) or 15:6 (10-bit period).
- R8: When control bit 13 (fast change) is set, a held sample is taken at the next period boundary without waiting for the repeat count to finish.
- R9: The left sample is data bits 15:0 and the right sample is data bits 31:16. When `stereoMode` is 0, `pwmRight` stays low and only bits 15:0 are used.
- R10: `sampleReq` is high exactly when the core is enabled and the holding register is empty. If no sample is waiting at a load point, the previous duty values keep being output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the sample rate is clk / (period x repeat) |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register byte offset |
| regWrData | input | 32 | Register write data |
| stereoMode | input | 1 | 1 selects two channels, 0 selects left channel only |
| sampleReq | output | 1 | Request for the next sample word |
| pwmLeft | output | 1 | Left channel PWM output |
| pwmRight | output | 1 | Right channel PWM output |

## Verification
The bench compares every clock of whole periods against an arithmetic model. The sweep covers all four alignment codes with samples at zero, full scale, mid scale, just below mid scale, a small value and an irregular value. Each sample is run in both sign modes. The right sample is a scrambled copy of the left one, so swapped or shared channels show up. A separate sweep over all eight shift amounts tells apart the truncation and the bit-selection steps. Runs with the 1024-clock period show whether the upper duty bits are used. Gap measurements between requests distinguish a load after the repeat count, a fast-change load, a hold-over after an underrun, and a write to an unused offset.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
  localparam int SAMPLE_W = 16;
  localparam int RES_LO_W = 8;
  localparam int RES_HI_W = 10;
  localparam int DUTY_W   = RES_HI_W;
  localparam int REP_W    = 9;
  localparam int SHIFT_W  = 3;
  localparam int CHANS    = 2;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_RIGHT  = 2'd1,
    ALIGN_CENTER = 2'd2
  } align_e;

  // Packed from MSB down so that bit 0 is the enable.
  typedef struct packed {
    logic [SHIFT_W-1:0] lsh;
    logic               signFlip;
    logic               fastChange;
    logic [REP_W-1:0]   repM1;
    logic [1:0]         align;
    logic               res10;
    logic               en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic holdWr;
    logic activeLoad;
  } strobe_t;
endpackage

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
  import pwmdac_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output ctrl_t             ctrlQ,
  output logic [DUTY_W-1:0] cnt,
  output strobe_t           strobe,
  output logic              sampleReq
);
  localparam logic [DUTY_W-1:0] LAST_LO = DUTY_W'((1 << RES_LO_W) - 1);
  localparam logic [DUTY_W-1:0] LAST_HI = DUTY_W'((1 << RES_HI_W) - 1);

  logic             ctrlWr, dataWr, holdFull, periodEnd, repDone;
  logic [DUTY_W-1:0] lastCnt;
  logic [REP_W-1:0]  repCnt;

  assign ctrlWr    = regWrEn && (regAddr == ADDR_W'(CTRL_OFS));
  assign dataWr    = regWrEn && (regAddr == ADDR_W'(DATA_OFS));
  assign lastCnt   = ctrlQ.res10 ? LAST_HI : LAST_LO;
  assign periodEnd = ctrlQ.en && (cnt >= lastCnt);
  assign repDone   = (repCnt == ctrlQ.repM1);

  assign strobe.holdWr     = dataWr;
  assign strobe.activeLoad = periodEnd && holdFull && (repDone || ctrlQ.fastChange);
  assign sampleReq         = ctrlQ.en && !holdFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= ctrl_t'(regWrData[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
    end else if (dataWr) begin
      holdFull <= 1'b1;
    end else if (strobe.activeLoad) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctrlQ.en) begin
      cnt    <= '0;
      repCnt <= '0;
    end else if (periodEnd) begin
      cnt    <= '0;
      repCnt <= (repDone || strobe.activeLoad) ? '0 : repCnt + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwmdac_datapath.sv
module pwmdac_datapath
  import pwmdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  ctrl_t                    ctrlQ,
  input  logic [31:0]              regWrData,
  input  logic [DUTY_W-1:0]        cnt,
  input  logic                     stereoMode,
  output logic [CHANS-1:0]         pwmOut,
  output logic [CHANS*DUTY_W-1:0]  dutyMon
);
  localparam int PER_W = DUTY_W + 1;

  logic [CHANS*SAMPLE_W-1:0] holdQ;
  logic [PER_W-1:0]          periodLen, cntExt;

  assign periodLen = ctrlQ.res10 ? PER_W'(1 << RES_HI_W) : PER_W'(1 << RES_LO_W);
  assign cntExt    = {1'b0, cnt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strobe.holdWr) begin
      holdQ <= regWrData[CHANS*SAMPLE_W-1:0];
    end
  end

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] raw, flipped, shifted;
    logic [DUTY_W-1:0]   dutyNext, dutyQ;
    logic [PER_W-1:0]    dutyExt, lo, hi;
    logic                hit, chanOn;

    assign raw      = holdQ[ch*SAMPLE_W +: SAMPLE_W];
    assign flipped  = ctrlQ.signFlip ? {~raw[SAMPLE_W-1], raw[SAMPLE_W-2:0]} : raw;
    assign shifted  = flipped << ctrlQ.lsh;
    assign dutyNext = ctrlQ.res10 ? shifted[SAMPLE_W-1 -: RES_HI_W]
                                  : DUTY_W'(shifted[SAMPLE_W-1 -: RES_LO_W]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dutyQ <= '0;
      end else if (strobe.activeLoad) begin
        dutyQ <= dutyNext;
      end
    end

    assign dutyExt = {1'b0, dutyQ};
    assign lo      = (periodLen - dutyExt) >> 1;
    assign hi      = lo + dutyExt;

    always_comb begin
      case (ctrlQ.align)
        ALIGN_RIGHT:  hit = cntExt >= (periodLen - dutyExt);
        ALIGN_CENTER: hit = (cntExt >= lo) && (cntExt < hi);
        default:      hit = cntExt < dutyExt;
      endcase
    end

    assign chanOn  = (ch == 0) || stereoMode;
    assign pwmOut[ch] = ctrlQ.en && chanOn && hit;
    assign dutyMon[ch*DUTY_W +: DUTY_W] = dutyQ;
  end
endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
  import pwmdac_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              stereoMode,
  output logic              sampleReq,
  output logic              pwmLeft,
  output logic              pwmRight
);
  ctrl_t                    ctrlQ;
  strobe_t                  strobe;
  logic [DUTY_W-1:0]        cnt;
  logic [CHANS-1:0]         pwmOut;
  logic [CHANS*DUTY_W-1:0]  dutyMon;

  pwmdac_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctrlQ(ctrlQ), .cnt(cnt), .strobe(strobe),
    .sampleReq(sampleReq)
  );

  pwmdac_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlQ(ctrlQ),
    .regWrData(regWrData), .cnt(cnt), .stereoMode(stereoMode),
    .pwmOut(pwmOut), .dutyMon(dutyMon)
  );

  assign pwmLeft  = pwmOut[0];
  assign pwmRight = pwmOut[1];
endmodule

// File: rtl/pwmdac_checker.sv
module pwmdac_checker
  import pwmdac_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input ctrl_t                   ctrlQ,
  input logic [DUTY_W-1:0]       cnt,
  input logic [CHANS*DUTY_W-1:0] dutyMon,
  input logic                    stereoMode,
  input logic                    sampleReq,
  input logic                    pwmLeft,
  input logic                    pwmRight
);
  logic [DUTY_W-1:0] lastCnt;
  assign lastCnt = ctrlQ.res10 ? DUTY_W'((1 << RES_HI_W) - 1) : DUTY_W'((1 << RES_LO_W) - 1);

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.en |-> (!pwmLeft && !pwmRight && !sampleReq));

  a_r9_mono_right_low: assert property (@(posedge clk) disable iff (!rstN)
    !stereoMode |-> !pwmRight);

  a_r10_req_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sampleReq) && $past(ctrlQ.en) && ctrlQ.en) |-> ($past(cnt) == $past(lastCnt)));

  a_r4_left_starts_high: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.en && ctrlQ.align == 2'd0 && cnt == '0) |-> (pwmLeft == (dutyMon[DUTY_W-1:0] != '0)));

  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.en && $past(ctrlQ.en) && $stable(ctrlQ.res10)) |-> (cnt <= lastCnt));
endmodule

bind pwm_audio_dac pwmdac_checker chk_i (
  .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .cnt(cnt), .dutyMon(dutyMon),
  .stereoMode(stereoMode), .sampleReq(sampleReq), .pwmLeft(pwmLeft),
  .pwmRight(pwmRight)
);

// File: tb/pwm_audio_dac_tb.sv
module pwm_audio_dac_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        stereoMode = 1'b1;
  logic        sampleReq, pwmLeft, pwmRight;

  int checks = 0;
  int failures = 0;
  bit cRes = 0, cSign = 0;
  int cAlign = 0, cShift = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_audio_dac dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .stereoMode(stereoMode), .sampleReq(sampleReq),
    .pwmLeft(pwmLeft), .pwmRight(pwmRight)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(bit en, bit res, int al, int repM1, bit chg, bit sg, int sh);
    return {14'b0, sh[2:0], sg, chg, repM1[8:0], al[1:0], res, en};
  endfunction

  // Arithmetic model of one output at period position c.
  function automatic bit expOut(logic [15:0] s, bit sg, int sh, bit r10, int al, int c);
    logic [15:0] v;
    int d, p, lo;
    v = sg ? (s ^ 16'h8000) : s;
    v = v << sh;
    d = r10 ? int'(v[15:6]) : int'(v[15:8]);
    p = r10 ? 1024 : 256;
    lo = (p - d) / 2;
    case (al)
      1: return c >= p - d;
      2: return (c >= lo) && (c < lo + d);
      default: return c < d;
    endcase
  endfunction

  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a;
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitReq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sampleReq);
  endtask

  task automatic loadAndSync(logic [15:0] sL, logic [15:0] sR, int repM1, bit chg);
    int n;
    busWr(3'd4, mkCtrl(0, cRes, cAlign, repM1, chg, cSign, cShift));
    busWr(3'd0, {sR, sL});
    busWr(3'd4, mkCtrl(1, cRes, cAlign, repM1, chg, cSign, cShift));
    waitReq(n);
  endtask

  // Compares one whole period, starting at the current negedge (position 0).
  task automatic capture(logic [15:0] sL, logic [15:0] sR, string tag);
    int p, errL, errR, badL, badR;
    bit eL, eR;
    p = cRes ? 1024 : 256;
    errL = 0; errR = 0; badL = -1; badR = -1;
    for (int i = 0; i < p; i++) begin
      if (i > 0) @(negedge clk);
      eL = expOut(sL, cSign, cShift, cRes, cAlign, i);
      eR = stereoMode ? expOut(sR, cSign, cShift, cRes, cAlign, i) : 1'b0;
      if (pwmLeft !== eL) begin errL++; if (badL < 0) badL = i; end
      if (pwmRight !== eR) begin errR++; if (badR < 0) badR = i; end
    end
    check(errL == 0, tag, $sformatf("left s=%h al=%0d sg=%0d sh=%0d res10=%0d first bad pos=%0d mismatches",
          sL, cAlign, cSign, cShift, cRes, badL), errL, 0);
    check(errR == 0, tag, $sformatf("right s=%h al=%0d sg=%0d sh=%0d res10=%0d first bad pos=%0d mismatches",
          sR, cAlign, cSign, cShift, cRes, badR), errR, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] samp [6];
    int n, bad;
    samp = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0100, 16'hA5C3};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!pwmLeft && !pwmRight && !sampleReq, "R1", "outputs after reset",
          {pwmLeft, pwmRight, sampleReq}, 0);

    // R4 R6 R9: alignment x sample x sign sweep, 8-bit period
    cRes = 0; cShift = 0;
    for (int al = 0; al < 4; al++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int k = 0; k < 6; k++) begin
          cAlign = al; cSign = bit'(sg);
          loadAndSync(samp[k], samp[k] ^ 16'h5A5A, 0, 0);
          capture(samp[k], samp[k] ^ 16'h5A5A, "R4_R6_R9");
        end
      end
    end

    // R7: shift sweep
    cAlign = 0; cSign = 0;
    for (int sh = 0; sh < 8; sh++) begin
      cShift = sh;
      loadAndSync(16'h0357, 16'h2C91, 0, 0);
      capture(16'h0357, 16'h2C91, "R7");
    end
    cShift = 0;

    // R3: 10-bit period, all alignments
    cRes = 1; cSign = 1;
    for (int al = 0; al < 3; al++) begin
      cAlign = al;
      loadAndSync(16'h1234, 16'hC0DE, 0, 0);
      capture(16'h1234, 16'hC0DE, "R3");
    end
    cRes = 0; cSign = 0; cAlign = 0;

    // R9: mono mode, only low half used, right low
    stereoMode = 1'b0;
    loadAndSync(16'h4000, 16'hFFFF, 0, 0);
    capture(16'h4000, 16'hFFFF, "R9");
    stereoMode = 1'b1;

    // R10: underrun holds previous sample, request stays high
    loadAndSync(16'h6000, 16'h2000, 0, 0);
    capture(16'h6000, 16'h2000, "R10");
    @(negedge clk);
    check(sampleReq == 1'b1, "R10", "request while empty", sampleReq, 1);
    capture(16'h6000, 16'h2000, "R10");

    // R2: write to unused offset does not fill the holding register
    @(negedge clk);
    busWr(3'd2, 32'h1111_2222);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!sampleReq) bad++;
    end
    check(bad == 0, "R2", "cycles with request low after unused-offset write", bad, 0);

    // R5: repeat count 3 periods before next sample
    loadAndSync(16'h3000, 16'h3000, 2, 0);
    busWr(3'd0, {16'h9000, 16'hE000});
    waitReq(n);
    check(n + 1 == 768, "R5", "cycles between loads with repeat 3", n + 1, 768);
    capture(16'hE000, 16'h9000, "R5");

    // R8: fast change loads at next boundary
    loadAndSync(16'h3000, 16'h3000, 2, 1);
    busWr(3'd0, {16'h1800, 16'hC800});
    waitReq(n);
    check(n + 1 == 256, "R8", "cycles between loads with fast change", n + 1, 256);
    capture(16'hC800, 16'h1800, "R8");

    // R1: disable holds outputs and request low
    loadAndSync(16'hF000, 16'hF000, 0, 0);
    busWr(3'd4, mkCtrl(0, 0, 0, 0, 0, 0, 0));
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwmLeft || pwmRight || sampleReq) bad++;
    end
    check(bad == 0, "R1", "active cycles while disabled", bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule